// File: doc/BRIEF.md
# Loadable Up/Down Binary/Decade Counter

This block is a 4-bit synchronous counter. It counts up or down, and it runs either as a binary counter over 0..15 or as a decade counter over 0..9. Both the direction select and the modulus select may change while the counter is running. Each new setting takes effect on the next clock edge, and counting carries on from whatever value the counter holds.

The block has no reset pin. A parallel load is the only way to give the counter a known value, so the system resets it by loading zero. A terminal-count output goes high while the count sits at the last value of its sequence for the current direction. A chain of these counters uses that output as its cascade carry.

Top module: `updn_counter`

## Requirements
- R1: When `ld_en` is 1, the next rising clock edge places `ld_val` into `count`, whatever the direction and mode. Load takes priority over counting, and a load of 0 serves as the reset.
- R2: In binary mode (`dec_mode` = 0) with `cnt_up` = 1, each clock adds one to the count, and 15 is followed by 0.
- R3: In binary mode with `cnt_up` = 0, each clock subtracts one from the count, and 0 is followed by 15.
- R4: In decade mode (`dec_mode` = 1) with `cnt_up` = 1, the count steps 0, 1, ..., 9, and 9 is followed by 0.
- R5: In decade mode with `cnt_up` = 0, each clock subtracts one from the count, and 0 is followed by 9.
- R6: In decade mode a count above 9 goes to 0 on the next upward clock. It is reduced by one on a downward clock.
- R7: Reversing `cnt_up` in the middle of a sequence continues from the present value. For example, counting up through 2, 3, 4 and then switching to down yields 3.
- R8: A change of `dec_mode` while running applies to the very next clock edge, with no load needed.
- R9: `term_out` is 1 exactly when the count is 15 (binary, up), 9 (decade, up) or 0 (down, either mode). It follows the present count and selects without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| ld_en | input | 1 | Parallel load enable, active high |
| ld_val | input | 4 | Value to load |
| dec_mode | input | 1 | 1 = decade (0..9), 0 = binary (0..15) |
| cnt_up | input | 1 | 1 = count up, 0 = count down |
| count | output | 4 | Present count |
| term_out | output | 1 | Terminal-count carry for the present direction |

## Verification
The assertions stay silent until the first load, because the count has no defined value before one. After that they assume every input is a clean 0 or 1 at each rising edge. The bench meets both conditions: it starts every run with a load of zero, and it changes inputs only on falling edges. Random stimulus loads on roughly one clock in sixteen, and the loaded values include 10 through 15, so decade mode often starts above its range. The direction and mode selects are redrawn on every clock, which exercises mid-sequence switching heavily. Directed cases cover the listed wrap points and the 2, 3, 4, 3 reversal.

// File: rtl/updn_counter.sv
module updn_counter #(
  parameter int W       = 4,
  parameter int DEC_TOP = 9
) (
  input  logic         clk,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic         dec_mode,
  input  logic         cnt_up,
  output logic [W-1:0] count,
  output logic         term_out
);
  localparam logic [W-1:0] BIN_T = '1;
  localparam logic [W-1:0] DEC_T = W'(DEC_TOP);

  logic [W-1:0] cnt_q, cnt_d, top_val;
  logic         at_zero, up_wrap;

  assign top_val = dec_mode ? DEC_T : BIN_T;
  assign at_zero = (cnt_q == '0);
  assign up_wrap = dec_mode ? (cnt_q >= DEC_T) : (cnt_q == BIN_T);

  always_comb begin
    if (ld_en)        cnt_d = ld_val;
    else if (cnt_up)  cnt_d = up_wrap ? '0 : cnt_q + 1'b1;
    else              cnt_d = at_zero ? top_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk) cnt_q <= cnt_d;

  assign count    = cnt_q;
  assign term_out = cnt_up ? (cnt_q == top_val) : at_zero;

  // Checks are armed once a load has given the count a defined value.
  logic chk_armed = 1'b0;
  always_ff @(posedge clk) if (ld_en) chk_armed <= 1'b1;

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!chk_armed)
    ld_en |=> count == $past(ld_val)); // R1
  AST_BIN_UP: assert property (@(posedge clk) disable iff (!chk_armed)
    (!ld_en && cnt_up && !dec_mode) |=> count == W'($past(count) + 1'b1)); // R2
  AST_BIN_DN_WRAP: assert property (@(posedge clk) disable iff (!chk_armed)
    (!ld_en && !cnt_up && !dec_mode && count == '0) |=> count == BIN_T); // R3
  AST_DEC_UP_WRAP: assert property (@(posedge clk) disable iff (!chk_armed)
    (!ld_en && cnt_up && dec_mode && count >= DEC_T) |=> count == '0); // R6
  AST_DEC_DN_WRAP: assert property (@(posedge clk) disable iff (!chk_armed)
    (!ld_en && !cnt_up && dec_mode && count == '0) |=> count == DEC_T); // R5
  AST_DN_STEP: assert property (@(posedge clk) disable iff (!chk_armed)
    (!ld_en && !cnt_up && count != '0) |=> count == W'($past(count) - 1'b1)); // R7
  AST_CARRY_UP: assert property (@(posedge clk) disable iff (!chk_armed)
    (!ld_en && cnt_up && term_out) |=> count == '0); // R9
  AST_CARRY_DN: assert property (@(posedge clk) disable iff (!chk_armed)
    (!ld_en && !cnt_up && term_out) |=> count == ($past(dec_mode) ? DEC_T : BIN_T)); // R9
endmodule

// File: tb/updn_counter_tb_top.sv
module updn_counter_tb_top;
  logic       clk = 1'b0;
  logic       ld_en = 1'b0, dec_mode = 1'b0, cnt_up = 1'b1;
  logic [3:0] ld_val = 4'd0;
  logic [3:0] count;
  logic       term_out;
  int checks = 0, failures = 0;
  logic [3:0] exp_c = 4'd0;
  bit done = 0;

  always #2 clk = ~clk;

  updn_counter dut_i (.clk(clk), .ld_en(ld_en), .ld_val(ld_val), .dec_mode(dec_mode),
                      .cnt_up(cnt_up), .count(count), .term_out(term_out));

  function automatic logic [3:0] ref_next(logic [3:0] c, logic ld, logic [3:0] v, logic dm, logic up);
    int lim = dm ? 9 : 15;
    if (ld) return v;
    if (up) return (int'(c) >= lim) ? 4'd0 : 4'(c + 1);
    return (c == 0) ? 4'(lim) : 4'(c - 1);
  endfunction

  function automatic logic ref_carry(logic [3:0] c, logic dm, logic up);
    if (!up) return c == 0;
    return dm ? (c == 9) : (c == 15);
  endfunction

  function automatic string tag_of(logic [3:0] c, logic ld, logic dm, logic up);
    if (ld) return "R1";
    if (dm && c > 9) return "R6";
    if (!dm) return up ? "R2" : "R3";
    return up ? "R4" : "R5";
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Drives at a falling edge, checks carry before the rising edge, count at the next falling edge.
  task automatic step(logic ld, logic [3:0] v, logic dm, logic up, string tag_in);
    string tag;
    ld_en = ld; ld_val = v; dec_mode = dm; cnt_up = up;
    #1;
    check("R9", term_out, ref_carry(exp_c, dm, up));
    tag = (tag_in.len() != 0) ? tag_in : tag_of(exp_c, ld, dm, up);
    exp_c = ref_next(exp_c, ld, v, dm, up);
    @(negedge clk);
    check(tag, count, exp_c);
  endtask

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    step(1, 4'd0, 0, 1, "R1");                       // load of zero as reset
    step(1, 4'd7, 1, 0, "R1");                       // load wins over counting
    step(1, 4'd14, 0, 1, "R1");
    step(0, 0, 0, 1, "R2"); step(0, 0, 0, 1, "R2");  // 15, then 0
    step(0, 0, 0, 0, "R3"); step(0, 0, 0, 0, "R3");  // 15, 14
    step(1, 4'd0, 0, 0, "R1"); step(0, 0, 0, 0, "R3");
    step(1, 4'd8, 1, 1, "R1");
    step(0, 0, 1, 1, "R4"); step(0, 0, 1, 1, "R4");  // 9, 0
    step(0, 0, 1, 0, "R5"); step(0, 0, 1, 0, "R5");  // 9, 8
    step(1, 4'd13, 0, 1, "R1");
    step(0, 0, 1, 0, "R6");                          // 12
    step(0, 0, 1, 1, "R6");                          // 0
    step(1, 4'd1, 1, 1, "R1");
    step(0, 0, 1, 1, "R7"); step(0, 0, 1, 1, "R7"); step(0, 0, 1, 1, "R7");
    step(0, 0, 1, 0, "R7");                          // 4 then 3
    check("R7", count, 3);
    step(1, 4'd9, 0, 1, "R1");
    step(0, 0, 0, 1, "R8");                          // binary: 10
    step(0, 0, 1, 1, "R8");                          // decade above range: 0
    for (int i = 0; i < 4000; i++) begin
      logic ld = ($urandom % 16) == 0;
      step(ld, 4'($urandom), 1'($urandom), 1'($urandom), "");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(100000 * 4);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule